// File: doc/BRIEF.md
# Receiver Automatic Restart Timer

This block decides when a packet receiver may start a fresh signal-strength acquisition after a packet has been delivered and drained by the host. A payload-complete indication arms the timer. The first clock cycle in which the receive FIFO reads empty while the timer is armed starts a wait. The wait lasts an exponential number of bit periods chosen by a 4-bit delay code. When the wait ends, a single-cycle restart pulse goes to the receive front end and the timer disarms.

Software can also request a restart directly. A one-cycle restart command cancels any wait in progress and issues the restart pulse on the next clock. The command works whether or not automatic restart is enabled. The bit-period tick comes from outside, and the acquisition logic that the pulse triggers is also outside this block.

Top module: `rx_restart_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), restart_pulse_o and waiting_o are both 0.
- R2: A clock edge that samples payload_ready_i = 1 with auto_en_i = 1 and restart_cmd_i = 0 arms the timer. waiting_o is 1 after that edge and stays 1 until the timer disarms.
- R3: While the timer is armed and fifo_empty_i has not yet been sampled high, bit ticks have no effect and no restart pulse is issued.
- R4: For a delay code n below 12, the wait is 2^n bit ticks. If edge k is the first edge that samples fifo_empty_i = 1 while the timer is armed, and a tick is driven in every p-th cycle after it, restart_pulse_o is high after edge k + p·2^n + 1.
- R5: The wait counter advances only in cycles where bit_tick_i is 1. Cycles without a tick extend the wait.
- R6: For a delay code of 12 to 15, the wait is zero ticks, and restart_pulse_o is high after edge k + 1.
- R7: The restart pulse lasts exactly one cycle. waiting_o is 0 in the same cycle as the pulse, and no further pulse follows until the timer is armed again.
- R8: While auto_en_i is 0, the timer does not arm. A wait already in progress is dropped, with waiting_o going to 0 and no automatic pulse issued.
- R9: A clock edge that samples restart_cmd_i = 1 makes restart_pulse_o 1 and waiting_o 0 after that edge. The command cancels any count in progress, and it works with auto_en_i at 0 or 1.
- R10: If the command arrives in the same cycle that the wait completes, exactly one pulse is issued.
- R11: Once the wait has started, fifo_empty_i going low does not stop or delay it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| payload_ready_i | input | 1 | Packet payload complete; arms the timer |
| fifo_empty_i | input | 1 | Receive FIFO is empty |
| bit_tick_i | input | 1 | One-cycle strobe for each bit period |
| delay_code_i | input | 4 | Delay code n: 2^n ticks for n below 12, zero for n of 12 or more |
| auto_en_i | input | 1 | Automatic restart enable |
| restart_cmd_i | input | 1 | One-cycle manual restart command |
| restart_pulse_o | output | 1 | One-cycle restart request to the front end |
| waiting_o | output | 1 | Timer armed (waiting for drain or counting) |

## Verification
Two functions can land in the same cycle: the automatic wait completing and the manual restart command. The bench provokes this with a delay code of 0 and a tick in every cycle. It asserts the command in exactly the cycle in which the counter reaches its target. The result passes only if the pulse appears after that edge, lasts one cycle, leaves waiting_o low, and no second pulse follows in the cycles after it.

// File: rtl/rx_restart_pkg.sv
// Package: shared constants for the receive restart timer.
// Assumes the delay counter is wide enough to hold 2^(ZERO_FROM-1).
package rx_restart_pkg;
    localparam int unsigned DEF_CODE_W    = 4;
    localparam int unsigned DEF_CNT_W     = 12;
    localparam int unsigned DEF_ZERO_FROM = 12;
endpackage

// File: rtl/rx_restart_target.sv
// Module: rx_restart_target
// Maps a delay code onto the number of bit ticks to wait: 2^code below
// ZERO_FROM, and zero from ZERO_FROM upward. Purely combinational.
// Assumes CNT_W > ZERO_FROM-1 so every nonzero target is representable.
module rx_restart_target #(
    parameter int unsigned CODE_W    = rx_restart_pkg::DEF_CODE_W,
    parameter int unsigned CNT_W     = rx_restart_pkg::DEF_CNT_W,
    parameter int unsigned ZERO_FROM = rx_restart_pkg::DEF_ZERO_FROM
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  target_o
);
    localparam int unsigned N_CODES = 1 << CODE_W;

    logic [CNT_W-1:0] lut [N_CODES];

    // One entry per code value, built by generate.
    for (genvar g = 0; g < N_CODES; g++) begin : g_entry
        if (g >= ZERO_FROM || g >= CNT_W) begin : g_zero
            assign lut[g] = '0;
        end else begin : g_pow
            assign lut[g] = CNT_W'(1) << g;
        end
    end

    // Select the entry for the present code.
    always_comb target_o = lut[code_i];
endmodule

// File: rtl/rx_restart_counter.sv
// Module: rx_restart_counter
// Tick counter for the restart wait: cleared on start, advances on request.
// Assumes the controller never asks it to advance past its target.
module rx_restart_counter #(
    parameter int unsigned CNT_W = rx_restart_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Hold, clear or advance the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (adv_i) cnt_o <= cnt_o + CNT_W'(1);
    end
endmodule

// File: rtl/rx_restart_ctrl.sv
// Module: rx_restart_ctrl
// Arm / count / fire control. Priority: manual command, then the auto
// disable, then completion, then arming and start. A disarm in the same
// cycle as payload_ready wins. The pulse is registered and lasts one cycle.
module rx_restart_ctrl #(
    parameter int unsigned CNT_W = rx_restart_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             payload_ready_i,
    input  logic             fifo_empty_i,
    input  logic             bit_tick_i,
    input  logic             auto_en_i,
    input  logic             restart_cmd_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             clr_o,
    output logic             adv_o,
    output logic             pulse_o,
    output logic             armed_o
);
    logic counting_q;
    logic fire;
    logic start;

    // Decide completion, start and advance for this cycle.
    always_comb begin
        fire  = counting_q && auto_en_i && (cnt_i == target_i);
        start = armed_o && fifo_empty_i && !counting_q && auto_en_i && !restart_cmd_i;
        clr_o = start;
        adv_o = counting_q && bit_tick_i && !fire;
    end

    // State update for armed, counting and the restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_o    <= 1'b0;
            counting_q <= 1'b0;
            pulse_o    <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            if (restart_cmd_i) begin
                pulse_o    <= 1'b1;
                armed_o    <= 1'b0;
                counting_q <= 1'b0;
            end else if (!auto_en_i) begin
                armed_o    <= 1'b0;
                counting_q <= 1'b0;
            end else if (fire) begin
                pulse_o    <= 1'b1;
                armed_o    <= 1'b0;
                counting_q <= 1'b0;
            end else begin
                if (payload_ready_i) armed_o    <= 1'b1;
                if (start)           counting_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_restart_timer.sv
// Module: rx_restart_timer (top)
// Issues a one-cycle restart pulse 2^n bit ticks after the FIFO drains
// following a payload, or at once on a manual command. Assumes bit_tick_i
// is a single-cycle strobe synchronous to clk.
module rx_restart_timer #(
    parameter int unsigned CODE_W    = rx_restart_pkg::DEF_CODE_W,
    parameter int unsigned CNT_W     = rx_restart_pkg::DEF_CNT_W,
    parameter int unsigned ZERO_FROM = rx_restart_pkg::DEF_ZERO_FROM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              payload_ready_i,
    input  logic              fifo_empty_i,
    input  logic              bit_tick_i,
    input  logic [CODE_W-1:0] delay_code_i,
    input  logic              auto_en_i,
    input  logic              restart_cmd_i,
    output logic              restart_pulse_o,
    output logic              waiting_o
);
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt;
    logic             clr;
    logic             adv;

    rx_restart_target #(.CODE_W(CODE_W), .CNT_W(CNT_W), .ZERO_FROM(ZERO_FROM)) u_target (
        .code_i   (delay_code_i),
        .target_o (target)
    );

    rx_restart_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .adv_i (adv),
        .cnt_o (cnt)
    );

    rx_restart_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .payload_ready_i (payload_ready_i),
        .fifo_empty_i    (fifo_empty_i),
        .bit_tick_i      (bit_tick_i),
        .auto_en_i       (auto_en_i),
        .restart_cmd_i   (restart_cmd_i),
        .target_i        (target),
        .cnt_i           (cnt),
        .clr_o           (clr),
        .adv_o           (adv),
        .pulse_o         (restart_pulse_o),
        .armed_o         (waiting_o)
    );
endmodule

// File: rtl/rx_restart_timer_checks.sv
// Module: rx_restart_timer_checks
// Port-level temporal properties of the restart timer, bound to the top.
module rx_restart_timer_checks (
    input logic clk,
    input logic rst_n,
    input logic payload_ready_i,
    input logic auto_en_i,
    input logic restart_cmd_i,
    input logic restart_pulse_o,
    input logic waiting_o
);
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (payload_ready_i && auto_en_i && !restart_cmd_i && !waiting_o) |=> waiting_o);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_pulse_o && !restart_cmd_i) |=> !restart_pulse_o);

    p_pulse_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse_o |-> !waiting_o);

    p_auto_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en_i && !restart_cmd_i) |=> (!restart_pulse_o && !waiting_o));

    p_cmd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_cmd_i |=> (restart_pulse_o && !waiting_o));
endmodule

bind rx_restart_timer rx_restart_timer_checks u_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .payload_ready_i (payload_ready_i),
    .auto_en_i       (auto_en_i),
    .restart_cmd_i   (restart_cmd_i),
    .restart_pulse_o (restart_pulse_o),
    .waiting_o       (waiting_o)
);

// File: tb/rx_restart_timer_bench.sv
module rx_restart_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       payload_ready_i = 1'b0;
    logic       fifo_empty_i = 1'b0;
    logic       bit_tick_i = 1'b0;
    logic [3:0] delay_code_i = 4'd0;
    logic       auto_en_i = 1'b1;
    logic       restart_cmd_i = 1'b0;
    logic       restart_pulse_o;
    logic       waiting_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rx_restart_timer u_rx_restart_timer (
        .clk(clk), .rst_n(rst_n), .payload_ready_i(payload_ready_i),
        .fifo_empty_i(fifo_empty_i), .bit_tick_i(bit_tick_i),
        .delay_code_i(delay_code_i), .auto_en_i(auto_en_i),
        .restart_cmd_i(restart_cmd_i), .restart_pulse_o(restart_pulse_o),
        .waiting_o(waiting_o)
    );

    // code, tick period, edges from drain edge to pulse
    typedef struct packed { logic [3:0] code; int unsigned period; int unsigned edges; } vec_t;
    localparam vec_t VECS [10] = '{
        '{4'd0,  1, 2},    '{4'd1, 1, 3},  '{4'd3, 1, 9},   '{4'd2, 3, 13},
        '{4'd4,  2, 33},   '{4'd5, 4, 129},'{4'd11, 1, 2049},'{4'd12, 1, 1},
        '{4'd15, 5, 1},    '{4'd13, 2, 1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Arm with FIFO not empty, then drain; returns with drain edge k just passed.
    task automatic arm_and_drain(input logic [3:0] code);
        @(negedge clk);
        delay_code_i = code; payload_ready_i = 1'b1; fifo_empty_i = 1'b0;
        step();
        @(negedge clk);
        payload_ready_i = 1'b0; fifo_empty_i = 1'b1; bit_tick_i = 1'b0;
        step();
    endtask

    // Walk ticks at the given period; record first pulse edge index and count.
    task automatic run_ticks(input int unsigned period, input int unsigned n,
                             output int first, output int count);
        first = -1; count = 0;
        for (int unsigned j = 1; j <= n; j++) begin
            @(negedge clk);
            bit_tick_i = ((j % period) == 0);
            step();
            if (restart_pulse_o) begin
                if (first < 0) first = int'(j);
                count++;
            end
        end
        @(negedge clk);
        bit_tick_i = 1'b0; fifo_empty_i = 1'b0;
    endtask

    initial begin
        int first, count;
        repeat (3) step();
        check(restart_pulse_o == 1'b0 && waiting_o == 1'b0, "R1", {restart_pulse_o, waiting_o}, 0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: R4, R5, R6, R7
        foreach (VECS[i]) begin
            arm_and_drain(VECS[i].code);
            check(waiting_o == 1'b1, "R2", waiting_o, 1);
            run_ticks(VECS[i].period, VECS[i].edges + 4, first, count);
            check(first == int'(VECS[i].edges),
                  (VECS[i].code >= 12) ? "R6" : (VECS[i].period > 1 ? "R5" : "R4"),
                  first, VECS[i].edges);
            check(count == 1 && waiting_o == 1'b0, "R7", count, 1);
        end

        // R3: armed but FIFO not drained; ticks do nothing
        @(negedge clk); delay_code_i = 4'd0; payload_ready_i = 1'b1;
        step();
        @(negedge clk); payload_ready_i = 1'b0;
        count = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk); bit_tick_i = 1'b1; step();
            if (restart_pulse_o) count++;
        end
        check(count == 0 && waiting_o == 1'b1, "R3", count, 0);
        @(negedge clk); fifo_empty_i = 1'b1; bit_tick_i = 1'b0; step();
        run_ticks(1, 6, first, count);
        check(first == 2, "R3", first, 2);

        // R8: auto disabled, no arming, no pulse
        @(negedge clk); auto_en_i = 1'b0; payload_ready_i = 1'b1; fifo_empty_i = 1'b1;
        step();
        @(negedge clk); payload_ready_i = 1'b0;
        check(waiting_o == 1'b0, "R8", waiting_o, 0);
        run_ticks(1, 20, first, count);
        check(count == 0, "R8", count, 0);
        @(negedge clk); auto_en_i = 1'b1;

        // R8: disable mid-count drops the wait
        arm_and_drain(4'd4);
        run_ticks(1, 5, first, count);
        @(negedge clk); auto_en_i = 1'b0; fifo_empty_i = 1'b1; bit_tick_i = 1'b1;
        step();
        check(waiting_o == 1'b0, "R8", waiting_o, 0);
        run_ticks(1, 30, first, count);
        check(count == 0, "R8", count, 0);
        @(negedge clk); auto_en_i = 1'b1;

        // R9: manual command cancels a count in progress
        arm_and_drain(4'd6);
        run_ticks(1, 10, first, count);
        @(negedge clk); restart_cmd_i = 1'b1; fifo_empty_i = 1'b1;
        step();
        check(restart_pulse_o == 1'b1 && waiting_o == 1'b0, "R9", {restart_pulse_o, waiting_o}, 2);
        @(negedge clk); restart_cmd_i = 1'b0;
        run_ticks(1, 100, first, count);
        check(count == 0, "R9", count, 0);

        // R9: manual command with auto disabled
        @(negedge clk); auto_en_i = 1'b0; restart_cmd_i = 1'b1;
        step();
        check(restart_pulse_o == 1'b1, "R9", restart_pulse_o, 1);
        @(negedge clk); restart_cmd_i = 1'b0; auto_en_i = 1'b1;

        // R10: command in the completing cycle gives one pulse
        arm_and_drain(4'd0);
        @(negedge clk); bit_tick_i = 1'b1; step();
        @(negedge clk); restart_cmd_i = 1'b1; step();
        first = restart_pulse_o;
        @(negedge clk); restart_cmd_i = 1'b0;
        run_ticks(1, 8, count, count);
        check(first == 1 && count == 0 && waiting_o == 1'b0, "R10", count, 0);

        // R11: FIFO leaving empty after start does not stop the wait
        arm_and_drain(4'd2);
        first = -1;
        for (int unsigned j = 1; j <= 9; j++) begin
            @(negedge clk);
            bit_tick_i = 1'b1;
            if (j == 2) fifo_empty_i = 1'b0;
            step();
            if (restart_pulse_o && first < 0) first = int'(j);
        end
        @(negedge clk); bit_tick_i = 1'b0;
        check(first == 5, "R11", first, 5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule